// File: doc/BRIEF.md
# External Bus Chip-Select and Wait-State Controller

This block sits between a small controller's bus interface and the pins of its external memory bus. Four address areas of the 1 MB space are decoded from each external access, and the matching active-low select is driven for the full length of the access. The access is stretched by zero to four wait cycles, and completion is signalled with a one-cycle done pulse. An 8-bit control register holds, for each area, an output-enable bit that decides whether its pin is a select or a general-purpose port pin, and a no-wait bit. A global input forces exactly one wait cycle on every area access.

The block also decides which of the eight upper address pins (address bits 12 to 19) carry latched address bits and which carry port values, based on a 2-bit bus-width code. It reports the data-bus width from a static byte-mode input.

Top module: `ext_bus_cs_ctrl`

## Requirements
- R1: After reset the control register reads 0x01, all selects are high, busy and done are low, and the latched upper address is 0.
- R2: When cfg_we is high at a clock edge the control register takes cfg_wdata. Bit i (i = 0..3) is the output enable of area i, and bit 4+i is the no-wait bit of area i. cfg_rdata always shows the register.
- R3: Area 0 is 0x40000-0x7FFFF, area 1 is 0x80000-0xBFFFF, area 2 is 0xC0000-0xDFFFF and area 3 is 0xE0000-0xEFFFF. If ranges overlap, the lowest index wins. Every other address is internal, and an internal access asserts no select.
- R4: At most one select is low at a time. A select goes low on the edge that accepts an access to an enabled area and stays low through every wait cycle of that access.
- R5: cs_pin[i] carries cs_n[i] when enable bit i is 1, and carries port_cs[i] when it is 0. An access to a disabled area still runs its wait timing but drives no select low.
- R6: With force_one_wait low, an area whose no-wait bit is 1 takes 0 wait cycles. An area whose no-wait bit is 0 takes wait_fld[2i+1:2i]+1 wait cycles (1 to 4).
- R7: With force_one_wait high, every access to any of the four areas takes exactly 1 wait cycle, whatever its no-wait bit.
- R8: busy is high for W+1 cycles after the accepting edge, where W is the wait count (W = 0 for internal accesses). acc_done is then high for exactly one cycle, and the select rises in that same cycle.
- R9: acc_req is ignored while busy. A request in the cycle where acc_done is high is accepted.
- R10: The wait count and select of an access are fixed at the accepting edge from the register value before any write on that edge. Later writes do not alter a running access.
- R11: addr_hi_pin follows width_sel. Code 00 drives all eight bits from the latched address. Code 01 drives bits 0..3 (address 12..15) from the address and bits 4..7 from port_hi. Codes 10 and 11 drive all eight bits from port_hi.
- R12: bus16 is high when byte_mode is low, and low when byte_mode is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| wait_fld | input | 8 | Four 2-bit wait-length fields, area i at bits 2i+1:2i |
| force_one_wait | input | 1 | Forces one wait cycle on all area accesses |
| width_sel | input | 2 | Upper address width code |
| byte_mode | input | 1 | High selects the 8-bit data bus |
| acc_req | input | 1 | Access request, sampled while idle |
| acc_addr | input | 20 | Access address |
| port_cs | input | 4 | Port values for select pins in port use |
| port_hi | input | 8 | Port values for upper address pins in port use |
| busy | output | 1 | Access in progress |
| acc_done | output | 1 | One-cycle completion pulse |
| cs_n | output | 4 | Registered active-low selects |
| cs_pin | output | 4 | Select pin values after the port mux |
| addr_hi_pin | output | 8 | Upper address pin values after the width mux |
| bus16 | output | 1 | High when the data bus is 16 bits wide |

## Verification
The interesting collision is a register write landing on the same edge that accepts an access, and a write landing while an access is still counting its wait cycles. The bench drives cfg_we together with acc_req, and again a cycle after it, with values that change both the enable and the no-wait bits. It then counts busy cycles and observes which select went low. These must match the value held before the write. A behavioural per-cycle model also runs under random traffic in which writes, held requests and done cycles overlap freely, and every output is compared each cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACC  = 1'b1
    } acc_state_e;

    typedef enum logic [1:0] {
        BW_FULL  = 2'b00,
        BW_MID   = 2'b01,
        BW_NARROW = 2'b10,
        BW_NARROW_ALT = 2'b11
    } bus_width_e;

endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
    parameter int N_AREA = 4,
    parameter int AW = 20,
    parameter logic [N_AREA*AW-1:0] AREA_LO = '0,
    parameter logic [N_AREA*AW-1:0] AREA_HI = '0
) (
    input  logic [AW-1:0]     addr,
    output logic [N_AREA-1:0] hit
);
    logic [N_AREA-1:0] raw_hit;

    for (genvar g = 0; g < N_AREA; g++) begin : g_range
        assign raw_hit[g] = (addr >= AREA_LO[g*AW +: AW]) &&
                            (addr <= AREA_HI[g*AW +: AW]);
    end

    always_comb begin
        hit = '0;
        for (int i = N_AREA - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit = '0;
                hit[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ebc_wait_sel.sv
module ebc_wait_sel #(
    parameter int N_AREA = 4,
    parameter int WFLD_W = 2,
    localparam int CNT_W = WFLD_W + 1
) (
    input  logic [N_AREA-1:0]        hit,
    input  logic [N_AREA-1:0]        no_wait,
    input  logic [N_AREA*WFLD_W-1:0] wait_fld,
    input  logic                     force_one,
    output logic [CNT_W-1:0]         waits
);
    always_comb begin
        waits = '0;
        for (int i = 0; i < N_AREA; i++) begin
            if (hit[i]) begin
                if (force_one)
                    waits = CNT_W'(1);
                else if (no_wait[i])
                    waits = '0;
                else
                    waits = {1'b0, wait_fld[i*WFLD_W +: WFLD_W]} + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ebc_pin_mux.sv
module ebc_pin_mux #(
    parameter int N_AREA = 4,
    parameter int HI_W = 8,
    parameter int MID_W = 4
) (
    input  logic [N_AREA-1:0]  cs_en,
    input  logic [N_AREA-1:0]  cs_n,
    input  logic [N_AREA-1:0]  port_cs,
    input  logic [HI_W-1:0]    addr_hi,
    input  logic [HI_W-1:0]    port_hi,
    input  ebc_pkg::bus_width_e bw,
    output logic [N_AREA-1:0]  cs_pin,
    output logic [HI_W-1:0]    addr_pin
);
    import ebc_pkg::*;

    for (genvar c = 0; c < N_AREA; c++) begin : g_cs
        assign cs_pin[c] = cs_en[c] ? cs_n[c] : port_cs[c];
    end

    for (genvar b = 0; b < HI_W; b++) begin : g_ahi
        logic is_addr;
        if (b < MID_W) begin : g_low
            assign is_addr = (bw == BW_FULL) || (bw == BW_MID);
        end else begin : g_up
            assign is_addr = (bw == BW_FULL);
        end
        assign addr_pin[b] = is_addr ? addr_hi[b] : port_hi[b];
    end
endmodule

// File: rtl/ext_bus_cs_ctrl.sv
module ext_bus_cs_ctrl #(
    parameter int N_AREA = 4,
    parameter int AW = 20,
    parameter int HI_LSB = 12,
    parameter int MID_MSB = 15,
    parameter int WFLD_W = 2,
    parameter logic [N_AREA*AW-1:0] AREA_LO =
        {20'hE0000, 20'hC0000, 20'h80000, 20'h40000},
    parameter logic [N_AREA*AW-1:0] AREA_HI =
        {20'hEFFFF, 20'hDFFFF, 20'hBFFFF, 20'h7FFFF},
    localparam int CTRL_W = 2 * N_AREA,
    localparam int CNT_W = WFLD_W + 1,
    localparam int HI_W = AW - HI_LSB,
    localparam int MID_W = MID_MSB + 1 - HI_LSB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CTRL_W-1:0]        cfg_wdata,
    output logic [CTRL_W-1:0]        cfg_rdata,
    input  logic [N_AREA*WFLD_W-1:0] wait_fld,
    input  logic                     force_one_wait,
    input  logic [1:0]               width_sel,
    input  logic                     byte_mode,
    input  logic                     acc_req,
    input  logic [AW-1:0]            acc_addr,
    input  logic [N_AREA-1:0]        port_cs,
    input  logic [HI_W-1:0]          port_hi,
    output logic                     busy,
    output logic                     acc_done,
    output logic [N_AREA-1:0]        cs_n,
    output logic [N_AREA-1:0]        cs_pin,
    output logic [HI_W-1:0]          addr_hi_pin,
    output logic                     bus16
);
    import ebc_pkg::*;

    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1);

    typedef struct packed {
        acc_state_e          st;
        logic [CTRL_W-1:0]   ctrl;
        logic [N_AREA-1:0]   sel;
        logic [CNT_W-1:0]    cnt;
        logic                done;
        logic [HI_W-1:0]     ahi;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_AREA-1:0] hit;
    logic [CNT_W-1:0]  waits;

    ebc_area_decode #(
        .N_AREA(N_AREA), .AW(AW), .AREA_LO(AREA_LO), .AREA_HI(AREA_HI)
    ) u_dec (
        .addr(acc_addr),
        .hit (hit)
    );

    ebc_wait_sel #(
        .N_AREA(N_AREA), .WFLD_W(WFLD_W)
    ) u_wait (
        .hit      (hit),
        .no_wait  (r_q.ctrl[CTRL_W-1:N_AREA]),
        .wait_fld (wait_fld),
        .force_one(force_one_wait),
        .waits    (waits)
    );

    always_comb begin
        r_d = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (acc_req) begin
                    r_d.st  = ST_ACC;
                    r_d.ahi = acc_addr[AW-1:HI_LSB];
                    r_d.sel = hit & r_q.ctrl[N_AREA-1:0];
                    r_d.cnt = waits;
                end
            end
            default: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.sel  = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
        endcase
        if (cfg_we)
            r_d.ctrl = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ctrl: CTRL_RST, sel: '0, cnt: '0,
                     done: 1'b0, ahi: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata = r_q.ctrl;
    assign busy      = (r_q.st == ST_ACC);
    assign acc_done  = r_q.done;
    assign cs_n      = ~r_q.sel;
    assign bus16     = ~byte_mode;

    ebc_pin_mux #(
        .N_AREA(N_AREA), .HI_W(HI_W), .MID_W(MID_W)
    ) u_mux (
        .cs_en   (r_q.ctrl[N_AREA-1:0]),
        .cs_n    (cs_n),
        .port_cs (port_cs),
        .addr_hi (r_q.ahi),
        .port_hi (port_hi),
        .bw      (bus_width_e'(width_sel)),
        .cs_pin  (cs_pin),
        .addr_pin(addr_hi_pin)
    );

    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cnt != '0) |=> (busy && $stable(cs_n)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (&cs_n && !busy));

    a_r9_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cnt != '0 && acc_req) |=> $stable(r_q.ahi));

    a_r7_force_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && acc_req && force_one_wait && (|hit)) |=> (r_q.cnt == CNT_W'(1)));

endmodule

// File: tb/tb_ext_bus_cs_ctrl.sv
`timescale 1ns/100ps
module tb_ext_bus_cs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] wait_fld = '0;
    logic       force_one_wait = 1'b0;
    logic [1:0] width_sel = 2'b00;
    logic       byte_mode = 1'b0;
    logic       acc_req = 1'b0;
    logic [19:0] acc_addr = '0;
    logic [3:0] port_cs = '0;
    logic [7:0] port_hi = '0;
    logic       busy, acc_done, bus16;
    logic [3:0] cs_n, cs_pin;
    logic [7:0] addr_hi_pin;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit timed_out = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    ext_bus_cs_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wait_fld(wait_fld),
        .force_one_wait(force_one_wait), .width_sel(width_sel),
        .byte_mode(byte_mode), .acc_req(acc_req), .acc_addr(acc_addr),
        .port_cs(port_cs), .port_hi(port_hi), .busy(busy),
        .acc_done(acc_done), .cs_n(cs_n), .cs_pin(cs_pin),
        .addr_hi_pin(addr_hi_pin), .bus16(bus16)
    );

    // behavioural reference state
    int m_ctrl, m_sel, m_cnt, m_busy, m_done, m_ahi;

    function automatic int area_of(input int a);
        if (a >= 'h40000 && a <= 'h7FFFF) return 0;
        if (a >= 'h80000 && a <= 'hBFFFF) return 1;
        if (a >= 'hC0000 && a <= 'hDFFFF) return 2;
        if (a >= 'hE0000 && a <= 'hEFFFF) return 3;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 1; m_sel = -1; m_cnt = 0; m_busy = 0; m_done = 0; m_ahi = 0;
        end else begin
            int old_ctrl;
            old_ctrl = m_ctrl;
            m_done = 0;
            if (m_busy != 0) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_sel = -1;
                end else m_cnt = m_cnt - 1;
            end else if (acc_req) begin
                int ar;
                ar = area_of(int'(acc_addr));
                m_busy = 1;
                m_ahi = int'(acc_addr[19:12]);
                m_sel = (ar >= 0 && old_ctrl[ar]) ? ar : -1;
                if (ar < 0) m_cnt = 0;
                else if (force_one_wait) m_cnt = 1;
                else if (old_ctrl[4+ar]) m_cnt = 0;
                else m_cnt = int'(wait_fld[2*ar +: 2]) + 1;
            end
            if (cfg_we) m_ctrl = int'(cfg_wdata);
        end
    end

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t",
                     tag, phase, what, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (cmp_en) begin
            logic [3:0] e_cs;
            logic [3:0] e_pin;
            logic [7:0] e_ahi;
            logic [7:0] mc;
            logic [7:0] ma;
            mc = m_ctrl[7:0];
            ma = m_ahi[7:0];
            e_cs = (m_sel < 0) ? 4'hF : ~(4'b0001 << m_sel);
            for (int i = 0; i < 4; i++) e_pin[i] = mc[i] ? e_cs[i] : port_cs[i];
            case (width_sel)
                2'b00: e_ahi = ma;
                2'b01: e_ahi = {port_hi[7:4], ma[3:0]};
                default: e_ahi = port_hi;
            endcase
            check("R2", "cfg_rdata", int'(cfg_rdata), int'(mc));
            check("R4", "cs_n", int'(cs_n), int'(e_cs));
            check("R5", "cs_pin", int'(cs_pin), int'(e_pin));
            check("R8", "acc_done", int'(acc_done), m_done);
            check("R9", "busy", int'(busy), m_busy);
            check("R11", "addr_hi_pin", int'(addr_hi_pin), int'(e_ahi));
            check("R12", "bus16", int'(bus16), int'(!byte_mode));
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // runs one access; optional write on the accepting edge
    task automatic do_acc(input string tag, input logic [19:0] a,
                          input int exp_idx, input int exp_w,
                          input bit wr_now, input logic [7:0] wv);
        int bcnt = 0;
        int seen = -1;
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a;
        if (wr_now) begin cfg_we = 1'b1; cfg_wdata = wv; end
        @(negedge clk);
        acc_req = 1'b0; cfg_we = 1'b0;
        for (int k = 0; k < 12; k++) begin
            #1;
            if (acc_done) break;
            if (busy) bcnt++;
            for (int i = 0; i < 4; i++) if (!cs_n[i]) seen = i;
            @(negedge clk);
        end
        check(tag, "busy cycles", bcnt, exp_w + 1);
        check(tag, "select index", seen, exp_idx);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk); #1;
        phase = "R1";
        check("R1", "reset ctrl", int'(cfg_rdata), 'h01);
        check("R1", "reset cs_n", int'(cs_n), 'hF);
        check("R1", "reset busy/done", int'({busy, acc_done}), 0);
        check("R1", "reset addr", int'(addr_hi_pin), 0);

        phase = "R6 default";
        wait_fld = 8'b00_00_00_10;
        do_acc("R6", 20'h45000, 0, 3, 1'b0, 8'h00);
        phase = "R5 disabled";
        port_cs = 4'b1010;
        do_acc("R5", 20'h90000, -1, 1, 1'b0, 8'h00);

        phase = "R2 write";
        wr(8'hFF);
        check("R2", "readback", int'(cfg_rdata), 'hFF);
        phase = "R3 areas no wait";
        do_acc("R3", 20'h7FFFF, 0, 0, 1'b0, 8'h00);
        do_acc("R3", 20'h80000, 1, 0, 1'b0, 8'h00);
        do_acc("R3", 20'hDFFFF, 2, 0, 1'b0, 8'h00);
        do_acc("R3", 20'hE0000, 3, 0, 1'b0, 8'h00);
        do_acc("R3", 20'h3FFFF, -1, 0, 1'b0, 8'h00);
        do_acc("R3", 20'hF0000, -1, 0, 1'b0, 8'h00);

        phase = "R6 fields";
        wr(8'h0F);
        wait_fld = {2'd3, 2'd0, 2'd1, 2'd2};
        do_acc("R6", 20'h50000, 0, 3, 1'b0, 8'h00);
        do_acc("R6", 20'hA0000, 1, 2, 1'b0, 8'h00);
        do_acc("R6", 20'hC8000, 2, 1, 1'b0, 8'h00);
        do_acc("R6", 20'hE8000, 3, 4, 1'b0, 8'h00);

        phase = "R7 force";
        force_one_wait = 1'b1;
        do_acc("R7", 20'hE8000, 3, 1, 1'b0, 8'h00);
        wr(8'hFF);
        do_acc("R7", 20'h40000, 0, 1, 1'b0, 8'h00);
        do_acc("R7", 20'h10000, -1, 0, 1'b0, 8'h00);
        force_one_wait = 1'b0;

        phase = "R10 collide";
        // write lands on accepting edge: old 0xFF rules (no wait, enabled)
        do_acc("R10", 20'hE4000, 3, 0, 1'b1, 8'h07);
        check("R10", "new ctrl", int'(cfg_rdata), 'h07);
        // area3 now disabled with waits; write mid-access must not alter it
        @(negedge clk);
        acc_req = 1'b1; acc_addr = 20'hE4000;
        @(negedge clk);
        acc_req = 1'b0; cfg_we = 1'b1; cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R10", "select after write", int'(cs_n), 'hF);
        check("R10", "still busy", int'(busy), 1);
        repeat (6) @(negedge clk);

        phase = "R9 held req";
        acc_req = 1'b1; acc_addr = 20'h60000;
        repeat (20) @(negedge clk);
        acc_req = 1'b0;
        repeat (3) @(negedge clk);

        phase = "R11 widths";
        port_hi = 8'h5A;
        do_acc("R11", 20'hABCDE, 1, 0, 1'b0, 8'h00);
        for (int w = 0; w < 4; w++) begin
            logic [7:0] e;
            width_sel = 2'(w);
            #1;
            e = (w == 0) ? 8'hAB : (w == 1) ? 8'h5B : 8'h5A;
            check("R11", "addr pins", int'(addr_hi_pin), int'(e));
            @(negedge clk);
        end

        phase = "R12 byte";
        byte_mode = 1'b1; #1;
        check("R12", "bus16 byte", int'(bus16), 0);
        @(negedge clk);
        byte_mode = 1'b0; #1;
        check("R12", "bus16 word", int'(bus16), 1);

        phase = "random";
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            acc_req = ($urandom_range(0, 2) == 0);
            acc_addr = 20'($urandom);
            cfg_we = ($urandom_range(0, 9) == 0);
            cfg_wdata = 8'($urandom);
            force_one_wait = ($urandom_range(0, 5) == 0);
            wait_fld = 8'($urandom);
            width_sel = 2'($urandom);
            port_cs = 4'($urandom);
            port_hi = 8'($urandom);
        end
        @(negedge clk);
        acc_req = 1'b0; cfg_we = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule